// File: doc/BRIEF.md
# Multi-word store to write-burst splitter

This block takes a store of one, two or three consecutive 32-bit words at a word-aligned byte address and turns it into the write address and write data traffic of an AXI-style interface with a 64-bit data bus. For every operation it emits the start address, an incrementing burst type, a transfer size, a burst length and the byte strobe of each data beat. It also steers every 32-bit word onto the bus lanes that match its address. A store is tagged write-through cacheable or noncacheable, and that tag travels with each address it produces.

Within a 32-byte aligned region, a pair of words that starts on an even word is sent as a single 64-bit beat. Every other multi-word store uses 32-bit beats. A store that would run past the end of its 32-byte region becomes two operations: the first ends at the region boundary and the second starts at offset zero of the next region. The request side is a plain valid/ready pair. A new store is taken only when the block is idle, and ready stays low until every address and data beat of the store has been handed off.

Top module: `stm_axi_splitter`

## Requirements
- R1: After reset `req_ready` is 1 and `aw_valid` and `w_valid` are 0. A request is taken only while `req_ready` is 1. `req_ready` is 0 from the cycle after acceptance until the last data beat of the store has been handed off.
- R2: Every issued address equals the start address of its operation. `aw_burst` is always 2'b01 (incrementing). `aw_len` is the beat count minus one. `aw_wt` equals the `req_wt` of the accepted request.
- R3: A two-word store at word index 0, 2, 4 or 6 (index = address bits [4:2]) is one beat with `aw_size` 3 (8 bytes) and strobe 8'hFF. The data is {second word, first word}, with the first word in bits [31:0].
- R4: A two-word store at word index 1, 3 or 5 has `aw_size` 2 (4 bytes) and two beats, with strobes 8'hF0 and then 8'h0F.
- R5: A three-word store at word index 0 to 5 has `aw_size` 2 and three beats. The strobes alternate and start at 8'h0F for an even index or at 8'hF0 for an odd index.
- R6: A one-word store has `aw_size` 2 and one beat. Its strobe is 8'h0F when address bit 2 is 0 and 8'hF0 when it is 1.
- R7: On every 4-byte beat the word is driven on both halves of `w_data`. Words go out in order: `req_data[31:0]` first, then `[63:32]`, then `[95:64]`.
- R8: Crossing stores are split into two operations. Two words at index 7 become one word, then one word. Three words at index 6 become two words (one 8-byte beat), then one word. Three words at index 7 become one word, then two words (one 8-byte beat at offset 0).
- R9: The second operation's address is the next 32-byte region with address bits [4:0] zero. Its address is offered only after the first address handshake, and no data beat of an operation is offered before its own address handshake.
- R10: `w_last` is 1 exactly on the final beat of each operation.
- R11: While `aw_valid` or `w_valid` waits for its ready, the valid signal stays high and the associated address or data fields hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Block idle and able to take a store |
| req_addr | input | ADDR_W | Word-aligned start byte address |
| req_words | input | 2 | Number of words, 1 to 3 |
| req_data | input | 96 | Store words, first word in bits [31:0] |
| req_wt | input | 1 | 1 = write-through cacheable, 0 = noncacheable |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address accepted |
| aw_addr | output | ADDR_W | Operation start address |
| aw_burst | output | 2 | Burst type, always incrementing |
| aw_size | output | 3 | Bytes per beat as log2 |
| aw_len | output | 8 | Beats minus one |
| aw_wt | output | 1 | Write-through tag of the store |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data accepted |
| w_data | output | 64 | Write data lanes |
| w_strb | output | 8 | Byte strobes |
| w_last | output | 1 | Final beat of the operation |

## Verification
The hardest situation to reach is a split store whose data channel is ready long before its address channel. In that case the data beats of the second operation must wait for an address handshake that has not happened yet. The stimulus uses a mode where `aw_ready` pulses only once every twelve cycles while `w_ready` stays high, and it sends every crossing start word through that mode. The scoreboard then checks that each data beat belongs to an operation whose address has already been taken.

// File: rtl/stm_axi_splitter.sv
module stm_axi_splitter #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_words,
  input  logic [95:0]       req_data,
  input  logic              req_wt,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [1:0]        aw_burst,
  output logic [2:0]        aw_size,
  output logic [7:0]        aw_len,
  output logic              aw_wt,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [63:0]       w_data,
  output logic [7:0]        w_strb,
  output logic              w_last
);

  localparam int REGION_LSB = 5;

  function automatic logic wide_beat(logic [ADDR_W-1:0] a, logic [1:0] n);
    return (n == 2'd2) && !a[2];
  endfunction

  function automatic logic [1:0] beat_cnt(logic [ADDR_W-1:0] a, logic [1:0] n);
    return wide_beat(a, n) ? 2'd1 : n;
  endfunction

  logic              busy, two_ops, wt_q;
  logic [ADDR_W-1:0] addr0, addr1;
  logic [1:0]        n0, n1;
  logic [95:0]       data_q;
  logic [1:0]        aw_done;
  logic              w_op;
  logic [1:0]        w_beat, w_word;

  // split decision at acceptance
  logic [2:0]        st_idx;
  logic [3:0]        end_idx;
  logic              crosses;
  logic [1:0]        first_n;
  logic [3:0]        room;
  assign st_idx  = req_addr[4:2];
  assign end_idx = {2'b0, req_words} + {1'b0, st_idx};
  assign crosses = end_idx > 4'd8;
  assign room    = 4'd8 - {1'b0, st_idx};
  assign first_n = crosses ? room[1:0] : req_words;

  logic accept;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  logic [1:0] nops;
  assign nops = two_ops ? 2'd2 : 2'd1;

  // address channel
  logic [ADDR_W-1:0] a_addr;
  logic [1:0]        a_n, a_beats;
  assign a_addr   = aw_done[0] ? addr1 : addr0;
  assign a_n      = aw_done[0] ? n1 : n0;
  assign a_beats  = beat_cnt(a_addr, a_n);
  assign aw_valid = busy && (aw_done < nops);
  assign aw_addr  = a_addr;
  assign aw_burst = 2'b01;
  assign aw_size  = wide_beat(a_addr, a_n) ? 3'd3 : 3'd2;
  assign aw_len   = {6'b0, a_beats - 2'd1};
  assign aw_wt    = wt_q;

  // data channel
  logic [ADDR_W-1:0] d_addr;
  logic [1:0]        d_n, d_beats;
  logic              d_wide, lane_hi;
  logic [127:0]      pad;
  logic [31:0]       wd0, wd1;
  logic [6:0]        lo_idx, hi_idx;
  assign d_addr  = w_op ? addr1 : addr0;
  assign d_n     = w_op ? n1 : n0;
  assign d_wide  = wide_beat(d_addr, d_n);
  assign d_beats = beat_cnt(d_addr, d_n);
  assign lane_hi = d_addr[2] ^ w_beat[0];
  assign pad     = {32'b0, data_q};
  assign lo_idx  = {w_word, 5'b0};
  assign hi_idx  = {w_word + 2'd1, 5'b0};
  assign wd0     = pad[lo_idx +: 32];
  assign wd1     = pad[hi_idx +: 32];
  assign w_valid = busy && (aw_done > {1'b0, w_op});
  assign w_data  = d_wide ? {wd1, wd0} : {wd0, wd0};
  assign w_strb  = d_wide ? 8'hFF : (lane_hi ? 8'hF0 : 8'h0F);
  assign w_last  = (w_beat == d_beats - 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      two_ops <= 1'b0;
      wt_q    <= 1'b0;
      addr0   <= '0;
      addr1   <= '0;
      n0      <= 2'd0;
      n1      <= 2'd0;
      data_q  <= '0;
      aw_done <= 2'd0;
      w_op    <= 1'b0;
      w_beat  <= 2'd0;
      w_word  <= 2'd0;
    end else if (accept) begin
      busy    <= 1'b1;
      two_ops <= crosses;
      wt_q    <= req_wt;
      addr0   <= req_addr;
      addr1   <= {req_addr[ADDR_W-1:REGION_LSB] + 1'b1, {REGION_LSB{1'b0}}};
      n0      <= first_n;
      n1      <= req_words - first_n;
      data_q  <= req_data;
      aw_done <= 2'd0;
      w_op    <= 1'b0;
      w_beat  <= 2'd0;
      w_word  <= 2'd0;
    end else begin
      if (aw_valid && aw_ready) aw_done <= aw_done + 2'd1;
      if (w_valid && w_ready) begin
        w_word <= w_word + (d_wide ? 2'd2 : 2'd1);
        if (w_last) begin
          w_beat <= 2'd0;
          if (w_op || !two_ops) busy <= 1'b0;
          else w_op <= 1'b1;
        end else begin
          w_beat <= w_beat + 2'd1;
        end
      end
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R1
  AST_WIDE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && aw_size == 3'd3 |-> aw_len == 8'd0 && aw_addr[2] == 1'b0); // R3
  AST_STRB_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && w_ready && !w_last && w_strb != 8'hFF |=> w_valid && w_strb == ~$past(w_strb)); // R5
  AST_SECOND_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && $past(aw_valid && aw_ready) && !$past(accept) |-> aw_addr[4:0] == 5'd0); // R9
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_len) && $stable(aw_size)); // R11
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_strb) && $stable(w_last)); // R11

endmodule

// File: tb/tb_stm_axi_splitter.sv
module tb_stm_axi_splitter;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready, req_wt = 0;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_words = 0;
  logic [95:0] req_data = 0;
  logic        aw_valid, aw_ready = 0, aw_wt;
  logic [31:0] aw_addr;
  logic [1:0]  aw_burst;
  logic [2:0]  aw_size;
  logic [7:0]  aw_len;
  logic        w_valid, w_ready = 0, w_last;
  logic [63:0] w_data;
  logic [7:0]  w_strb;

  stm_axi_splitter #(.ADDR_W(32)) dut (.*);

  always #4 clk = ~clk;

  typedef struct { logic [31:0] addr; logic [2:0] size; logic [7:0] len; string tag; } aw_t;
  typedef struct { logic [63:0] data; logic [7:0] strb; logic last; int seq; string tag; } w_t;
  aw_t aw_q[$];
  w_t  w_q[$];
  int  checks = 0, errors = 0, op_seq = 0, aw_seen = 0, mode = 0, cyc = 0;
  logic exp_wt = 0;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_op(logic [31:0] a, int n, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, string tag);
    logic [31:0] w[3];
    w[0] = w0; w[1] = w1; w[2] = w2;
    if (n == 2 && a[2] == 1'b0) begin
      aw_q.push_back('{a, 3'd3, 8'd0, tag});
      w_q.push_back('{{w1, w0}, 8'hFF, 1'b1, op_seq, tag});
    end else begin
      aw_q.push_back('{a, 3'd2, 8'(n - 1), tag});
      for (int b = 0; b < n; b++) begin
        logic hi;
        hi = a[2] ^ b[0];
        w_q.push_back('{{w[b], w[b]}, hi ? 8'hF0 : 8'h0F, b == n - 1, op_seq, {tag, "/R7"}});
      end
    end
    op_seq++;
  endtask

  task automatic store(logic [31:0] a, int n, logic [95:0] d, logic wt);
    int wi;
    string tag;
    logic [31:0] nx;
    wi = a[4:2];
    nx = {a[31:5] + 27'd1, 5'b0};
    if (n == 1) tag = "R6";
    else if (wi + n > 8) tag = "R8";
    else if (n == 2) tag = wi[0] ? "R4" : "R3";
    else tag = "R5";
    while (!req_ready) @(negedge clk);
    if (wi + n > 8) begin
      int f;
      f = 8 - wi;
      if (f == 1) push_op(a, 1, d[31:0], 0, 0, tag);
      else push_op(a, 2, d[31:0], d[63:32], 0, tag);
      if (f == 1) push_op(nx, n - 1, d[63:32], d[95:64], 0, "R9");
      else push_op(nx, 1, d[95:64], 0, 0, "R9");
    end else begin
      push_op(a, n, d[31:0], d[63:32], d[95:64], tag);
    end
    exp_wt = wt;
    req_valid = 1; req_addr = a; req_words = 2'(n); req_data = d; req_wt = wt;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    case (mode)
      0: begin aw_ready <= 1; w_ready <= 1; end
      1: begin aw_ready <= ($urandom % 3) != 0; w_ready <= ($urandom % 3) != 0; end
      default: begin aw_ready <= (cyc % 12) == 0; w_ready <= 1; end
    endcase
  end

  logic        aw_hold = 0, w_hold = 0;
  logic [31:0] aw_prev;
  logic [63:0] w_prev;

  always @(negedge clk) if (rst_n) begin
    if (aw_hold) check(aw_valid && aw_addr == aw_prev, "R11", "aw held", aw_addr, aw_prev);
    if (w_hold) check(w_valid && w_data == w_prev, "R11", "w held", w_data, w_prev);
    aw_hold = aw_valid && !aw_ready; aw_prev = aw_addr;
    w_hold = w_valid && !w_ready; w_prev = w_data;
    if (w_valid && w_ready) begin
      if (w_q.size() == 0) check(0, "R1", "unexpected beat", w_data, 0);
      else begin
        w_t e;
        e = w_q.pop_front();
        check(w_data == e.data, e.tag, "w_data", w_data, e.data);
        check(w_strb == e.strb, e.tag, "w_strb", w_strb, e.strb);
        check(w_last == e.last, "R10", "w_last", w_last, e.last);
        check(e.seq < aw_seen, "R9", "data before its address", aw_seen, e.seq + 1);
      end
    end
    if (aw_valid && aw_ready) begin
      if (aw_q.size() == 0) check(0, "R1", "unexpected address", aw_addr, 0);
      else begin
        aw_t e;
        e = aw_q.pop_front();
        check(aw_addr == e.addr, "R2", "aw_addr", aw_addr, e.addr);
        check(aw_burst == 2'b01, "R2", "aw_burst", aw_burst, 1);
        check(aw_wt == exp_wt, "R2", "aw_wt", aw_wt, exp_wt);
        check(aw_size == e.size, e.tag, "aw_size", aw_size, e.size);
        check(aw_len == e.len, "R2", "aw_len", aw_len, e.len);
      end
      aw_seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    check(aw_valid == 1'b0 && w_valid == 1'b0, "R1", "reset valids", {aw_valid, w_valid}, 0);
    for (int m = 0; m < 2; m++) begin
      mode = m;
      for (int n = 1; n <= 3; n++)
        for (int i = 0; i < 8; i++)
          store(32'h4000_1000 + 32'(m * 32'h100) + 32'(i * 4), n,
                {$urandom, $urandom, $urandom}, 1'((i + n) & 1));
    end
    mode = 2;
    store(32'h0000_FFFC, 2, 96'h0_11111111_22222222, 1);
    store(32'h0000_0038, 3, 96'hAAAAAAAA_BBBBBBBB_CCCCCCCC, 0);
    store(32'h0000_007C, 3, 96'h33333333_44444444_55555555, 1);
    store(32'h0000_0024, 2, 96'h0_66666666_77777777, 0);
    store(32'hFFFF_FFFC, 1, 96'h0_0_88888888, 1);
    repeat (4) @(negedge clk);
    check(aw_q.size() == 0 && w_q.size() == 0, "R10", "queues drained",
          aw_q.size() + w_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule